// File: doc/BRIEF.md
# Processor reset-entry sequencer

This block produces the bus activity an 8-bit processor with a 16-bit address space shows between the release of reset and its first instruction fetch. It runs the same step pattern as an interrupt entry, but every step is a read. First it issues dummy reads at the program counter, which stays unchanged. Then it makes three reads in page one at the stack pointer, and the stack pointer drops by one after each. Last it reads the two bytes of the start vector.

From the two vector bytes taken off the data bus it loads the program counter and sets the interrupt-disable flag. It then raises a fetch strobe that hands the bus to normal opcode fetch at the new address. The data bus is its only input. Its outputs are the address, the read-not-write strobe, the stack pointer, the status register, the program counter and the fetch strobe. The reset values, the number of dummy and stack reads and the vector location are parameters.

Top module: `cpu_reset_seq`

## Requirements
- R1: The read-not-write output `rnw` is 1 in every cycle, during reset, during the sequence and after it.
- R2: In cycles 0 and 1 after reset release, the address equals the program counter. The program counter keeps its reset value (default 0x00FF) until the vector-high cycle ends.
- R3: In cycles 2, 3 and 4, the address is 0x0100 plus the stack pointer (0x01C0, 0x01BF, 0x01BE with the default 0xC0). The stack pointer drops by one at the end of each of these cycles, ends three lower (0xBD) and does not change otherwise.
- R4: Cycle 5 reads address 0xFFFC (vector low byte) and cycle 6 reads 0xFFFD (vector high byte).
- R5: Status bit 2 (interrupt disable) is set at the end of cycle 5. It reads 1 from cycle 6 on, and the other status bits keep their reset value (default 0x02, so 0x06 afterwards).
- R6: From cycle 7 on, the program counter equals {byte read in cycle 6, byte read in cycle 5}. The address equals the program counter and `fetch` is 1. Before cycle 7, `fetch` is 0.
- R7: Asserting `rst_n` low at any point in or after the sequence returns all outputs to their reset values. After release, the sequence starts again from cycle 0.
- R8: While `rst_n` is low, the address equals the reset program counter, the stack pointer is 0xC0, the status is 0x02 and `fetch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the sequence |
| data_in | input | 8 | Data bus value for the current address |
| addr | output | 16 | Bus address of the current cycle |
| rnw | output | 1 | Read-not-write strobe, 1 for read |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status register |
| pc | output | 16 | Program counter |
| fetch | output | 1 | 1 when the current cycle is a normal opcode fetch |

## Verification
Several properties are checked on every cycle. The stack pointer falls by exactly one after each stack read and holds otherwise. The program counter holds outside the vector-high cycle. The interrupt flag is set while the high byte is read. The low-vector address appears in its own phase. Once `fetch` is raised it stays high, and its cycle addresses the program counter. Only the bench scenarios can show the exact cycle position of each phase, the vector value assembled from the data bus, the reset-time values and a restart from a reset asserted mid-sequence or after hand-off. The bench shows these by comparing a cycle-indexed model on every clock for several vector values.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    PH_DUMMY,
    PH_STACK,
    PH_VLO,
    PH_VHI,
    PH_RUN
  } rseq_phase_e;

  localparam int IFLAG_BIT = 2;

  // Page-one address for a stack pointer value.
  function automatic logic [15:0] stack_addr(input logic [7:0] s);
    return {8'h01, s};
  endfunction

  // Program counter from the two vector bytes.
  function automatic logic [15:0] join_vec(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  // Status with the interrupt-disable flag forced on.
  function automatic logic [7:0] with_iflag(input logic [7:0] p);
    logic [7:0] r;
    r = p;
    r[IFLAG_BIT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/rseq_step_ctr.sv
module rseq_step_ctr
  import rseq_pkg::*;
#(
  parameter int DUMMY_READS = 2,
  parameter int STACK_READS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  output rseq_phase_e phase
);
  localparam int TOTAL = DUMMY_READS + STACK_READS + 2;
  localparam int W     = $clog2(TOTAL + 1);
  localparam logic [W-1:0] STK_FIRST = W'(DUMMY_READS);
  localparam logic [W-1:0] VLO_STEP  = W'(DUMMY_READS + STACK_READS);
  localparam logic [W-1:0] VHI_STEP  = W'(DUMMY_READS + STACK_READS + 1);
  localparam logic [W-1:0] RUN_STEP  = W'(TOTAL);

  logic [W-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               step <= '0;
    else if (step != RUN_STEP) step <= step + 1'b1;
  end

  always_comb begin
    if (step < STK_FIRST)      phase = PH_DUMMY;
    else if (step < VLO_STEP)  phase = PH_STACK;
    else if (step == VLO_STEP) phase = PH_VLO;
    else if (step == VHI_STEP) phase = PH_VHI;
    else                       phase = PH_RUN;
  end

  // Once handed off, the sequencer never re-enters an earlier phase.
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (phase == PH_RUN));

endmodule

// File: rtl/rseq_addr_mux.sv
module rseq_addr_mux
  import rseq_pkg::*;
#(
  parameter logic [15:0] VEC_LO = 16'hFFFC
) (
  input  rseq_phase_e phase,
  input  logic [15:0] pc,
  input  logic [7:0]  sp,
  output logic [15:0] addr,
  output logic        rnw
);
  localparam logic [15:0] VEC_HI = VEC_LO + 16'd1;

  always_comb begin
    unique case (phase)
      PH_STACK: addr = stack_addr(sp);
      PH_VLO:   addr = VEC_LO;
      PH_VHI:   addr = VEC_HI;
      default:  addr = pc;
    endcase
  end

  // The reset path never writes; the first fetch after it is a read as well.
  assign rnw = 1'b1;

endmodule

// File: rtl/rseq_regs.sv
module rseq_regs
  import rseq_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h00FF,
  parameter logic [7:0]  RESET_SP = 8'hC0,
  parameter logic [7:0]  RESET_P  = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  rseq_phase_e phase,
  input  logic [7:0]  data_in,
  output logic [15:0] pc,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic [7:0]  vec_lo
);
  logic stack_step, lo_step, hi_step;
  assign stack_step = (phase == PH_STACK);
  assign lo_step    = (phase == PH_VLO);
  assign hi_step    = (phase == PH_VHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= RESET_PC;
      sp     <= RESET_SP;
      status <= RESET_P;
      vec_lo <= '0;
    end else begin
      if (stack_step) sp <= sp - 8'd1;
      if (lo_step) begin
        vec_lo <= data_in;
        status <= with_iflag(status);
      end
      if (hi_step) pc <= join_vec(data_in, vec_lo);
    end
  end

  a_r3_sp_dec: assert property (@(posedge clk) disable iff (!rst_n)
    stack_step |=> (sp == $past(sp) - 8'd1));
  a_r3_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stack_step |=> $stable(sp));
  a_r2_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_step |=> $stable(pc));
  a_r5_iflag_on: assert property (@(posedge clk) disable iff (!rst_n)
    hi_step |-> status[IFLAG_BIT]);
  a_r6_pc_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
    hi_step |=> (pc[15:8] == $past(data_in)));

endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
  import rseq_pkg::*;
#(
  parameter int          DUMMY_READS = 2,
  parameter int          STACK_READS = 3,
  parameter logic [15:0] VEC_LO      = 16'hFFFC,
  parameter logic [15:0] RESET_PC    = 16'h00FF,
  parameter logic [7:0]  RESET_SP    = 8'hC0,
  parameter logic [7:0]  RESET_P     = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  data_in,
  output logic [15:0] addr,
  output logic        rnw,
  output logic [7:0]  sp,
  output logic [7:0]  status,
  output logic [15:0] pc,
  output logic        fetch
);
  rseq_phase_e phase;
  logic [7:0]  vec_lo;

  rseq_step_ctr #(
    .DUMMY_READS(DUMMY_READS),
    .STACK_READS(STACK_READS)
  ) u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .phase(phase)
  );

  rseq_regs #(
    .RESET_PC(RESET_PC),
    .RESET_SP(RESET_SP),
    .RESET_P (RESET_P)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .data_in(data_in),
    .pc     (pc),
    .sp     (sp),
    .status (status),
    .vec_lo (vec_lo)
  );

  rseq_addr_mux #(
    .VEC_LO(VEC_LO)
  ) u_mux (
    .phase(phase),
    .pc   (pc),
    .sp   (sp),
    .addr (addr),
    .rnw  (rnw)
  );

  assign fetch = (phase == PH_RUN);

  a_r4_vec_lo_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_VLO) |-> (addr == VEC_LO));
  a_r4_vec_hi_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_VLO) |=> (addr == VEC_LO + 16'd1));
  a_r6_fetch_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (addr == pc));
  a_r6_pc_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch) |-> (pc[7:0] == vec_lo));
  a_r1_read_only: assert property (@(posedge clk) rnw);

endmodule

// File: tb/cpu_reset_seq_tb.sv
module cpu_reset_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data_in;
  logic [15:0] addr, pc;
  logic [7:0]  sp, status;
  logic        rnw, fetch;

  int          errors = 0;
  int          checks = 0;
  int          k = 0;
  logic [15:0] vec = 16'h1234;
  bit          restarted = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_reset_seq u_dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in),
    .addr(addr), .rnw(rnw), .sp(sp), .status(status), .pc(pc), .fetch(fetch)
  );

  // Bench memory: vector bytes at 0xFFFC/0xFFFD, filler elsewhere.
  always_comb begin
    if (addr == 16'hFFFC)      data_in = vec[7:0];
    else if (addr == 16'hFFFD) data_in = vec[15:8];
    else                       data_in = addr[7:0] ^ addr[15:8] ^ 8'h5A;
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, k);
    end
  endtask

  // Reference model indexed by cycles since release, compared every clock.
  always @(negedge clk) begin
    if (!finished) begin
      int e_addr, e_sp, e_st, e_pc, e_f;
      string t;
      cmp("R1", "rnw", int'(rnw), 1);
      if (!rst_n) begin
        cmp(restarted ? "R7" : "R8", "addr", int'(addr), 16'h00FF);
        cmp("R8", "sp", int'(sp), 8'hC0);
        cmp("R8", "status", int'(status), 8'h02);
        cmp("R8", "pc", int'(pc), 16'h00FF);
        cmp("R8", "fetch", int'(fetch), 0);
        k = 0;
      end else begin
        if (k < 2)       begin e_addr = 16'h00FF;                   t = "R2"; end
        else if (k < 5)  begin e_addr = 16'h0100 + 8'hC0 - (k - 2); t = "R3"; end
        else if (k == 5) begin e_addr = 16'hFFFC;                   t = "R4"; end
        else if (k == 6) begin e_addr = 16'hFFFD;                   t = "R4"; end
        else             begin e_addr = int'(vec);                  t = "R6"; end
        e_sp = (k <= 2) ? 8'hC0 : (k >= 5) ? 8'hBD : 8'hC0 - (k - 2);
        e_st = (k >= 6) ? 8'h06 : 8'h02;
        e_pc = (k >= 7) ? int'(vec) : 16'h00FF;
        e_f  = (k >= 7) ? 1 : 0;
        if (restarted && k == 0) t = "R7";
        cmp(t, "addr", int'(addr), e_addr);
        cmp("R3", "sp", int'(sp), e_sp);
        cmp("R5", "status", int'(status), e_st);
        cmp((k >= 7) ? "R6" : "R2", "pc", int'(pc), e_pc);
        cmp("R6", "fetch", int'(fetch), e_f);
        k++;
      end
    end
  end

  task automatic release_and_run(input int cycles);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (cycles) @(posedge clk);
    #1 rst_n = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    release_and_run(12);              // vector 0x1234
    vec = 16'hABCD; restarted = 1;
    repeat (2) @(posedge clk);
    release_and_run(3);               // R7: reset during stack phase
    repeat (2) @(posedge clk);
    release_and_run(12);              // full rerun with 0xABCD
    vec = 16'h0000;
    repeat (2) @(posedge clk);
    release_and_run(8);               // R7: reset after hand-off
    vec = 16'hFFFC;
    repeat (2) @(posedge clk);
    release_and_run(11);              // vector pointing at itself
    repeat (2) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule